// File: doc/BRIEF.md
# Montgomery Modular Multiplier

This block computes the Montgomery product P = A·B·2^(−n) mod M for unsigned n-bit operands and an odd modulus M. It works bit-serially over A, least significant bit first. Each step conditionally adds B, adds M if the running sum is odd so that the sum becomes even, and then halves the sum exactly with a right shift. After the last step, one correction brings the result below M. That correction forms the uncorrected value and its difference with M side by side and picks one of them. Mapping values into and out of the Montgomery domain is left to the surrounding logic.

Operands arrive on a valid/ready input channel. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. The block takes one operation at a time. `in_ready` stays low from the accepting edge until the result has been handed over. The result leaves on a valid/ready output channel. `out_valid` and `out_data` hold steady for as long as `out_ready` is low, so the consumer can exert back-pressure for as many cycles as it needs.

Top module: `mont_mul`

## Requirements
- R1: In reset and directly after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Operands are captured only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in the cycle that follows such an edge.
- R3: When M is odd and A, B < M, the internal sum stays below 2M after every step, so an accumulator of n+2 bits never overflows.
- R4: When M is odd and A, B < M, `out_data` is below M and `out_data`·2^n ≡ A·B (mod M).
- R5: `out_valid` first reads 1 after the (n+1)th rising edge that follows the accepting edge: n edges for the steps and one for the correction.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R7: `in_valid` asserted with other operands while an operation is in flight is not accepted and does not change that operation's result.
- R8: After an edge with `out_valid` and `out_ready` both 1, `out_valid` is 0 and `in_ready` is 1.
- R9: Boundary cases give the exact reduced value: A = 0 or B = 0 gives 0, M = 1 gives 0, and operands of 2^n − 2 with M = 2^n − 1 give a result below M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Block can accept an operand set |
| in_a | input | WIDTH | Multiplier A, scanned from bit 0 upward |
| in_b | input | WIDTH | Multiplicand B |
| in_m | input | WIDTH | Modulus M, must be odd |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | WIDTH | Montgomery product, below M |

## Verification
The bench builds the block with WIDTH = 16. At that width the products A·B and P·2^n fit in 64-bit bench arithmetic, so every result is checked exactly against a reference computed with the modular inverse of two. The small width also makes the edge moduli practical to test: M = 1, M = 3 and M = 2^16 − 1 are all covered, the last one with operands at its ceiling where the sum comes close to 2M. The latency of 17 cycles is short enough to probe directly. This leaves time to hold back-pressure over several cycles and to present colliding input during each run.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CORR = 2'd2,
    ST_HOLD = 2'd3
  } mont_state_e;
endpackage

// File: rtl/mont_step.sv
// One bit-serial Montgomery iteration: add B on the scanned bit of A,
// add M when the sum is odd, then halve exactly.
module mont_step #(
  parameter int WIDTH = 32,
  localparam int AW = WIDTH + 1,
  localparam int EW = WIDTH + 2
) (
  input  logic [AW-1:0]    acc_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic             a_bit_i,
  output logic [AW-1:0]    acc_o
);
  logic [EW-1:0] with_b;
  logic [EW-1:0] with_m;

  always_comb begin
    with_b = {1'b0, acc_i} + (a_bit_i ? {2'b00, b_i} : '0);
    with_m = with_b + (with_b[0] ? {2'b00, m_i} : '0);
    acc_o  = with_m[EW-1:1];
  end
endmodule

// File: rtl/mont_correct.sv
// Final correction: both candidates formed at once, borrow selects.
module mont_correct #(
  parameter int WIDTH = 32,
  localparam int AW = WIDTH + 1,
  localparam int EW = WIDTH + 2
) (
  input  logic [AW-1:0]    acc_i,
  input  logic [WIDTH-1:0] m_i,
  output logic [WIDTH-1:0] res_o
);
  logic [EW-1:0] diff;
  logic          borrow;

  always_comb begin
    diff   = {1'b0, acc_i} - {2'b00, m_i};
    borrow = diff[EW-1];
    res_o  = borrow ? acc_i[WIDTH-1:0] : diff[WIDTH-1:0];
  end
endmodule

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic step_en,
  output logic corr_en
);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mont_state_e   state;
  logic [CW-1:0] cnt;

  always_comb begin
    in_ready  = (state == ST_IDLE);
    out_valid = (state == ST_HOLD);
    load      = in_ready && in_valid;
    step_en   = (state == ST_RUN);
    corr_en   = (state == ST_CORR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_CORR;
        end
        ST_CORR: state <= ST_HOLD;
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted transfer closes the input channel next cycle
  p_accept_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R6: result is held under back-pressure
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R8: handing over the result reopens the input
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  // R5: the step counter never runs past the last scanned bit
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (cnt <= LAST));
endmodule

// File: rtl/mont_mul.sv
module mont_mul
  import mont_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AW = WIDTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_m,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic             load, step_en, corr_en;
  logic [WIDTH-1:0] a_sh, b_q, m_q, res_q;
  logic [AW-1:0]    acc_q, acc_nxt;
  logic [WIDTH-1:0] res_nxt;

  mont_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .step_en   (step_en),
    .corr_en   (corr_en)
  );

  mont_step #(.WIDTH(WIDTH)) u_step (
    .acc_i   (acc_q),
    .b_i     (b_q),
    .m_i     (m_q),
    .a_bit_i (a_sh[0]),
    .acc_o   (acc_nxt)
  );

  mont_correct #(.WIDTH(WIDTH)) u_corr (
    .acc_i (acc_q),
    .m_i   (m_q),
    .res_o (res_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh  <= '0;
      b_q   <= '0;
      m_q   <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (load) begin
        a_sh  <= in_a;
        b_q   <= in_b;
        m_q   <= in_m;
        acc_q <= '0;
      end else if (step_en) begin
        a_sh  <= a_sh >> 1;
        acc_q <= acc_nxt;
      end
      if (corr_en) res_q <= res_nxt;
    end
  end

  assign out_data = res_q;

  // R3: running sum stays below 2M, so n+2 bits suffice
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (acc_q < {m_q, 1'b0}));

  // R4: delivered result is reduced below the modulus
  p_result_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && m_q[0]) |-> (out_data < m_q));

  // R6: data is stable while the consumer stalls
  p_out_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R7: operands do not move while a run is in flight
  p_operands_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> ($stable(b_q) && $stable(m_q)));
endmodule

// File: tb/mont_mul_bench.sv
module mont_mul_bench;
  localparam int W = 16;
  localparam int NV = 12;
  // each entry: {a, b, m}
  localparam logic [3*W-1:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 16'h0001},
    {16'h0000, 16'h1234, 16'h5679},
    {16'h4321, 16'h0000, 16'h5679},
    {16'h0001, 16'h0001, 16'h0003},
    {16'h0002, 16'h0002, 16'h0003},
    {16'hFFFE, 16'hFFFE, 16'hFFFF},
    {16'h0001, 16'h0001, 16'hFFFF},
    {16'h7FFF, 16'h8000, 16'hFFFD},
    {16'h1234, 16'h5678, 16'h9ABD},
    {16'h00FF, 16'h00FE, 16'h0101},
    {16'hAAAA, 16'h5555, 16'hC001},
    {16'h0003, 16'h0005, 16'h0007}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_a = '0, in_b = '0, in_m = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mont_mul #(.WIDTH(W)) u_mont_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_m(in_m), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic longint mont_ref(longint a, longint b, longint m);
    longint r = (a * b) % m;
    longint half = (m + 1) / 2;
    for (int i = 0; i < W; i++) r = (r * half) % m;
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Sends one operation, waits for it, takes the result.
  task automatic run_op(input logic [W-1:0] a, b, m,
                        output logic [W-1:0] p, output int lat);
    @(negedge clk);
    in_a = a; in_b = b; in_m = m; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    p = out_data;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic check_result(input logic [W-1:0] a, b, m, p, input int lat);
    longint e = mont_ref(a, b, m);
    check("R4 residue", longint'(p), e);
    check("R4 below M", longint'(p < m), 1);
    check("R5 latency", lat, W + 1);
    check("R8 reopen", longint'({in_ready, out_valid}), 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [W-1:0] p;
    int lat;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in_ready in reset", in_ready, 1);
    check("R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after reset", in_ready, 1);
    check("R1 out_valid after reset", out_valid, 0);

    // R4 R9: table of vectors
    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] a, b, m;
      {a, b, m} = VEC[i];
      run_op(a, b, m, p, lat);
      check_result(a, b, m, p, lat);
    end
    // R9: zero and unit-modulus boundaries
    run_op(16'h0000, 16'h1234, 16'h5679, p, lat);
    check("R9 zero operand", p, 0);
    run_op(16'h0000, 16'h0000, 16'h0001, p, lat);
    check("R9 M of one", p, 0);
    run_op(16'hFFFE, 16'hFFFE, 16'hFFFF, p, lat);
    check("R9 top operands", p, mont_ref(16'hFFFE, 16'hFFFE, 16'hFFFF));

    // R3 R4: random odd moduli
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b, m;
      m = W'($urandom) | 16'h0001;
      a = W'($urandom % m);
      b = W'($urandom % m);
      run_op(a, b, m, p, lat);
      check_result(a, b, m, p, lat);
    end

    // R2 R7: colliding input while busy
    @(negedge clk);
    in_a = 16'h2468; in_b = 16'h1357; in_m = 16'hF00D; in_valid = 1'b1;
    @(negedge clk);
    check("R2 closed after accept", in_ready, 0);
    in_a = 16'h0001; in_b = 16'h0001; in_m = 16'h0003;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R7 not ready while busy", in_ready, 0);
    end
    lat = 0;
    while (!out_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    check("R7 result unchanged", out_data, mont_ref(16'h2468, 16'h1357, 16'hF00D));

    // R6: back-pressure
    p = out_data;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R6 valid held", out_valid, 1);
      check("R6 data held", out_data, p);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R8 reopen after stall", longint'({in_ready, out_valid}), 2);

    summary();
  end
endmodule